// File: doc/BRIEF.md
# Floating-Point Load-Multiple Sequencer

This block carries out one decoded load-multiple into the extension (floating-point) register file. A start request gives a 32-bit base address, an addressing direction, a writeback flag, the register precision, an optional explicit size, the index of the first register and the number of registers. The block first checks the request against the legality rules. A request that breaks any rule causes a one-cycle `illegal` pulse, and nothing else happens.

A legal request sets `busy`. The block then issues word reads on a valid/ready memory request port, at consecutive ascending addresses. Read data comes back in order on a response strobe and is forwarded to the register file write port. Registers are written in ascending index order. Each double-precision register takes two word beats.

When the last word has been written, the block pulses `done`. If writeback was requested, it also presents the updated base address. The block has no condition-flag outputs.

Top module: `fp_ldm_seq`

## Requirements
- R1: In ascending mode (`start_dec`=0), the first read is at `start_base`. Each later read is 4 bytes above the one before it.
- R2: In descending mode (`start_dec`=1), reads still rise in 4-byte steps. They start at `start_base` minus the total transfer size in bytes, so the last word read sits just below `start_base`. Total bytes are 4 times the count for singles and 8 times the count for doubles.
- R3: A legal transfer ends with a one-cycle `done` pulse. In that same cycle, `wb_valid` equals the writeback flag. When `wb_valid` is 1, `wb_value` is base plus total bytes in ascending mode, or base minus total bytes in descending mode, modulo 2^32.
- R4: A descending request with the writeback flag clear is illegal.
- R5: A register count of zero is illegal.
- R6: In double precision (`start_dbl`=1), a count above 16 is illegal; a count of exactly 16 is legal.
- R7: When `start_size_vld`=1, `start_size_64` (1 = 64-bit, 0 = 32-bit) must equal `start_dbl`; a mismatch is illegal.
- R8: A request whose first index plus count exceeds 32 is illegal; a sum of exactly 32 is legal.
- R9: Each double register is loaded in two beats. The lower-addressed word is written with `rf_hi`=0 (low half), and the next word with `rf_hi`=1 (high half). Single loads always have `rf_hi`=0.
- R10: Register writes carry `rf_idx` = first index, then first+1, and so on in ascending order. `rf_data` is the read data returned for the matching address.
- R11: `busy` rises the cycle after a legal start is accepted and falls in the cycle `done` is high. A start pulse while `busy` is 1 is ignored.
- R12: An illegal request produces exactly one `illegal` pulse in the cycle after the start. It issues no reads, performs no register writes, does not raise `busy` and does not pulse `done`.
- R13: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request address is held steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request strobe, taken when not busy |
| start_base | input | 32 | Base address |
| start_dec | input | 1 | 1 = descending (decrement-before), 0 = ascending (increment-after) |
| start_wb | input | 1 | Writeback of updated base requested |
| start_dbl | input | 1 | 1 = 64-bit registers, 0 = 32-bit registers |
| start_size_vld | input | 1 | Explicit size supplied |
| start_size_64 | input | 1 | Explicit size: 1 = 64, 0 = 32 |
| start_first | input | 5 | First register index |
| start_count | input | 6 | Number of registers |
| busy | output | 1 | Transfer in progress |
| illegal | output | 1 | One-cycle pulse: request rejected |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Word read address |
| mem_rsp_valid | input | 1 | Read data valid (in request order) |
| mem_rsp_data | input | 32 | Read data |
| rf_we | output | 1 | Register file write enable |
| rf_idx | output | 5 | Register index being written |
| rf_hi | output | 1 | 1 = high half of a double |
| rf_data | output | 32 | Write data |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | Updated base is reported (with done) |
| wb_value | output | 32 | Updated base value |

## Verification
The legal requests cover both directions crossed with both precisions. Their read-address lists separate the ascending start from the descending start. The `rf_idx`/`rf_hi` sequence of the double cases shows the two-beat split, which a single load cannot reveal.

A run of 32 singles from just below the top of the address space checks that the writeback sum wraps. The illegal requests each break exactly one rule and sit next to a legal neighbour at the boundary (count 16 versus 17, sum 32 versus 33), so an off-by-one in any rule shows up. Some legal runs have stalling memory, which separates address holding from stepping.

// File: rtl/fp_ldm_seq.sv
module fp_ldm_seq #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int RIDX_W = 5,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     start_base,
  input  logic              start_dec,
  input  logic              start_wb,
  input  logic              start_dbl,
  input  logic              start_size_vld,
  input  logic              start_size_64,
  input  logic [RIDX_W-1:0] start_first,
  input  logic [CNT_W-1:0]  start_count,
  output logic              busy,
  output logic              illegal,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DW-1:0]     mem_rsp_data,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_idx,
  output logic              rf_hi,
  output logic [DW-1:0]     rf_data,
  output logic              done,
  output logic              wb_valid,
  output logic [AW-1:0]     wb_value
);

  localparam int NREG    = 1 << RIDX_W;
  localparam int MAX_DBL = NREG / 2;
  localparam int BW      = CNT_W + 1;
  localparam int STEP    = DW / 8;

  logic [BW-1:0] s_beats;
  logic [AW-1:0] s_bytes;
  logic [BW-1:0] s_span;
  logic          s_bad;
  logic          accept;

  assign s_beats = start_dbl ? {start_count, 1'b0} : {1'b0, start_count};
  assign s_bytes = AW'(s_beats) * AW'(STEP);
  assign s_span  = BW'(start_first) + BW'(start_count);
  assign s_bad   = (start_count == '0)
                 | (start_dbl && start_count > CNT_W'(MAX_DBL))
                 | (start_size_vld && (start_size_64 != start_dbl))
                 | (start_dec && !start_wb)
                 | (s_span > BW'(NREG));
  assign accept  = start && !busy;

  logic [BW-1:0]     beats_q, issued_q, recvd_q;
  logic [RIDX_W-1:0] first_q;
  logic              dbl_q, wbf_q;
  logic [AW-1:0]     wbv_q;

  assign mem_req_valid = busy && (issued_q != beats_q);
  assign rf_we         = busy && mem_rsp_valid;
  assign rf_data       = mem_rsp_data;
  assign rf_hi         = dbl_q & recvd_q[0];
  assign rf_idx        = first_q + (dbl_q ? recvd_q[RIDX_W:1] : recvd_q[RIDX_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      illegal      <= 1'b0;
      done         <= 1'b0;
      wb_valid     <= 1'b0;
      wb_value     <= '0;
      mem_req_addr <= '0;
      beats_q      <= '0;
      issued_q     <= '0;
      recvd_q      <= '0;
      first_q      <= '0;
      dbl_q        <= 1'b0;
      wbf_q        <= 1'b0;
      wbv_q        <= '0;
    end else begin
      illegal  <= 1'b0;
      done     <= 1'b0;
      wb_valid <= 1'b0;
      if (accept) begin
        illegal <= s_bad;
        if (!s_bad) begin
          busy         <= 1'b1;
          beats_q      <= s_beats;
          issued_q     <= '0;
          recvd_q      <= '0;
          first_q      <= start_first;
          dbl_q        <= start_dbl;
          wbf_q        <= start_wb;
          mem_req_addr <= start_dec ? start_base - s_bytes : start_base;
          wbv_q        <= start_dec ? start_base - s_bytes : start_base + s_bytes;
        end
      end else if (busy) begin
        if (mem_req_valid && mem_req_ready) begin
          issued_q     <= issued_q + 1'b1;
          mem_req_addr <= mem_req_addr + AW'(STEP);
        end
        if (rf_we) begin
          recvd_q <= recvd_q + 1'b1;
          if (recvd_q == beats_q - 1'b1) begin
            busy     <= 1'b0;
            done     <= 1'b1;
            wb_valid <= wbf_q;
            wb_value <= wbf_q ? wbv_q : '0;
          end
        end
      end
    end
  end

endmodule

module fp_ldm_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          illegal,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          rf_we,
  input logic          done,
  input logic          wb_valid
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R13
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && busy) |=> (!mem_req_valid || mem_req_addr == $past(mem_req_addr) + 4)); // R1
  AST_ILLEGAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!busy && !mem_req_valid && !done)); // R12
  AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !illegal); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done); // R3
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R11
  AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || rf_we) |-> busy); // R11
endmodule

bind fp_ldm_seq fp_ldm_seq_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .illegal(illegal),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .rf_we(rf_we), .done(done), .wb_valid(wb_valid)
);

// File: tb/fp_ldm_seq_tb_top.sv
module fp_ldm_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start = 0, start_dec = 0, start_wb = 0, start_dbl = 0;
  logic        start_size_vld = 0, start_size_64 = 0;
  logic [31:0] start_base = 0;
  logic [4:0]  start_first = 0;
  logic [5:0]  start_count = 0;
  logic        busy, illegal, mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [31:0] mem_req_addr, mem_rsp_data, rf_data, wb_value;
  logic        rf_we, rf_hi, done, wb_valid;
  logic [4:0]  rf_idx;

  fp_ldm_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_base(start_base),
    .start_dec(start_dec), .start_wb(start_wb), .start_dbl(start_dbl),
    .start_size_vld(start_size_vld), .start_size_64(start_size_64),
    .start_first(start_first), .start_count(start_count),
    .busy(busy), .illegal(illegal), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_hi(rf_hi), .rf_data(rf_data),
    .done(done), .wb_valid(wb_valid), .wb_value(wb_value)
  );

  int errors = 0;
  int checks = 0;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'd3) ^ 32'h5A5A_C3C3;
  endfunction

  // memory model and monitor
  logic [31:0] q_addr [64];
  int q_head = 0, q_tail = 0;
  int cyc = 0;
  logic stall_en = 0;
  logic [31:0] req_log [64];
  logic [31:0] wr_data [64];
  logic [4:0]  wr_idx [64];
  logic        wr_hi [64];
  int nreq = 0, nwr = 0, ndone = 0, nill = 0;
  logic seen_wbv = 0;
  logic [31:0] seen_wb = 0;

  initial begin
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    mem_req_ready = stall_en ? cyc[0] : 1'b1;
    if (q_head != q_tail && (!stall_en || cyc[1])) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = memf(q_addr[q_head % 64]);
      q_head = q_head + 1;
    end else begin
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = 32'hDEAD_BEEF;
    end
    #1;
    if (mem_req_valid && mem_req_ready) begin
      q_addr[q_tail % 64] = mem_req_addr;
      q_tail = q_tail + 1;
      if (nreq < 64) req_log[nreq] = mem_req_addr;
      nreq = nreq + 1;
    end
    if (rf_we) begin
      if (nwr < 64) begin
        wr_idx[nwr] = rf_idx; wr_hi[nwr] = rf_hi; wr_data[nwr] = rf_data;
      end
      nwr = nwr + 1;
    end
    if (done) begin
      ndone = ndone + 1; seen_wbv = wb_valid; seen_wb = wb_value;
    end
    if (illegal) nill = nill + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    nreq = 0; nwr = 0; ndone = 0; nill = 0; seen_wbv = 0; seen_wb = 0;
  endtask

  task automatic launch(input logic [48:0] v);
    @(negedge clk);
    start_base = v[48:17]; start_dec = v[16]; start_wb = v[15]; start_dbl = v[14];
    start_size_vld = v[13]; start_size_64 = v[12]; start_first = v[11:7]; start_count = v[6:1];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (ndone == 0 && nill == 0 && n < 600) begin
      @(negedge clk);
      n++;
    end
    if (n >= 600) chk(0, "timeout", 0, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic verify(input logic [48:0] v, input string tag);
    logic [31:0] base = v[48:17];
    logic dec = v[16], wb = v[15], dbl = v[14];
    logic [4:0] first = v[11:7];
    logic [5:0] count = v[6:1];
    logic exp_ill = v[0];
    int beats = dbl ? 2 * count : count;
    logic [31:0] bytes = 32'(beats) * 4;
    logic [31:0] a0 = dec ? base - bytes : base;
    logic [31:0] ewb = dec ? base - bytes : base + bytes;
    bit ok;
    if (exp_ill) begin
      chk(nill == 1, {tag, " R12 illegal pulse count"}, nill, 1);
      chk(nreq == 0 && nwr == 0 && ndone == 0, {tag, " R12 no activity"}, nreq + nwr + ndone, 0);
    end else begin
      chk(nill == 0, {tag, " legal request flagged"}, nill, 0);
      chk(nreq == beats, {tag, " R1/R2 read count"}, nreq, beats);
      ok = 1;
      for (int k = 0; k < beats && k < nreq && k < 64; k++)
        if (req_log[k] !== a0 + 32'(4 * k)) ok = 0;
      chk(ok, {tag, dec ? " R2 descending addresses" : " R1 ascending addresses"}, req_log[0], a0);
      chk(nwr == beats, {tag, " R10 write count"}, nwr, beats);
      ok = 1;
      for (int k = 0; k < beats && k < nwr && k < 64; k++) begin
        if (wr_idx[k] !== first + 5'(dbl ? k / 2 : k)) ok = 0;
        if (wr_data[k] !== memf(a0 + 32'(4 * k))) ok = 0;
      end
      chk(ok, {tag, " R10 register order and data"}, wr_idx[0], first);
      ok = 1;
      for (int k = 0; k < beats && k < nwr && k < 64; k++)
        if (wr_hi[k] !== (dbl ? k[0] : 1'b0)) ok = 0;
      chk(ok, {tag, " R9 half select"}, wr_hi[beats > 1 ? 1 : 0], dbl);
      chk(ndone == 1 && seen_wbv == wb, {tag, " R3 done and wb_valid"}, {30'd0, ndone[0], seen_wbv}, {30'd0, 1'b1, wb});
      if (wb) chk(seen_wb == ewb, {tag, " R3 writeback value"}, seen_wb, ewb);
    end
  endtask

  // {base, dec, wb, dbl, size_vld, size_64, first, count, expect_illegal}
  localparam logic [48:0] VEC [12] = '{
    {32'h0000_1000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd2,  6'd3,  1'b0}, // R1 R3 R10
    {32'h0000_2000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 5'd4,  6'd2,  1'b0}, // R2 R9
    {32'h0000_2000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  6'd2,  1'b1}, // R4
    {32'h0000_3000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd0,  6'd1,  1'b0}, // R3 no wb, R7 match
    {32'h0000_4000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  6'd0,  1'b1}, // R5
    {32'h0000_5000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 5'd0,  6'd17, 1'b1}, // R6
    {32'h0000_8000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 5'd0,  6'd16, 1'b0}, // R6 boundary
    {32'h0000_6000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 5'd0,  6'd2,  1'b1}, // R7
    {32'h0000_7000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd30, 6'd3,  1'b1}, // R8
    {32'h0000_0010, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd29, 6'd3,  1'b0}, // R8 boundary, R2
    {32'h0000_9000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 5'd0,  6'd1,  1'b1}, // R7
    {32'hFFFF_FF80, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  6'd32, 1'b0}  // R3 wrap, R8
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 0 && mem_req_valid === 0 && done === 0 && illegal === 0 && rf_we === 0,
        "reset state", {27'd0, busy, mem_req_valid, done, illegal, rf_we}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      stall_en = i[0];
      clear_log();
      launch(VEC[i]);
      wait_end();
      verify(VEC[i], $sformatf("vec%0d", i));
    end

    // R11: busy after start, second start ignored while busy
    stall_en = 1;
    clear_log();
    launch({32'h0000_A000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 5'd1, 6'd4, 1'b0});
    chk(busy === 1'b1, "R11 busy after legal start", busy, 1);
    @(negedge clk);
    start_base = 32'h0000_B000; start_count = 6'd1; start_dbl = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_end();
    verify({32'h0000_A000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 5'd1, 6'd4, 1'b0}, "R11 restart ignored");
    chk(busy === 1'b0, "R11 busy falls after done", busy, 0);

    // R12: illegal does not raise busy
    stall_en = 0;
    clear_log();
    launch({32'h0000_C000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0, 6'd1, 1'b1});
    chk(busy === 1'b0, "R12 busy stays low on illegal", busy, 0);
    wait_end();
    verify({32'h0000_C000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0, 6'd1, 1'b1}, "R4 double");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule